// File: doc/BRIEF.md
# Doorbell Interrupt Dispatcher

This block sits on the card side of a host link. It watches a 32-bit MMIO write port and turns host doorbell writes into single-cycle interrupt pulses, one output line per doorbell. Sixteen doorbells are split into two ranges, and each range has its own trigger rule.

The lower eight doorbells each own an interrupt command register. These registers are spaced 8 bytes apart. A doorbell in this range fires only when the host writes the command word with the send bit (bit 13) set. The register keeps every other bit that was written. The send bit is never stored, so a read-modify-write of the register sets it again and fires again.

The upper eight doorbells are reached through a bank of status registers spaced 4 bytes apart. Doorbell d (8..15) uses status index d − 8 + 17. Any write to that index raises the pulse, whatever the data. Other indices in the bank do nothing. Ordering against earlier posted writes is the job of the logic upstream.

Top module: `db_dispatch`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, every `db_pulse` line is 0 and `rd_data` is 0. Every command register is cleared by reset.
- R2: A write to byte offset 0xA9D0 + 8·d (d = 0..7) with `wr_data` bit 13 set raises `db_pulse[d]`. The pulse appears in the cycle after the write edge and lasts exactly one cycle.
- R3: A command register write with bit 13 clear raises no pulse, but its data is still stored.
- R4: A read of a command register offset returns the last written word with bit 13 forced to 0. `rd_data` is registered: it reflects `rd_addr` at the previous edge. Writing the read-back word again with bit 13 set fires again.
- R5: A write of any value, including zero, to offset 0xB180 + 4·(d − 8 + 17) (d = 8..15) raises `db_pulse[d]` for exactly one cycle, one cycle after the write.
- R6: Writes to status indices 0..16 and 25..31 (offsets 0xB180..0xB1C0 and 0xB1E4..0xB1FC) raise no pulse.
- R7: Writes to any other offset raise no pulse and change no command register. This covers the upper word of a command slot (+4), misaligned addresses, and slots past the last doorbell.
- R8: Writes to doorbells on consecutive cycles each produce their own pulse in consecutive cycles, with none lost. Two writes in a row to the same doorbell hold its line high for two cycles.
- R9: At most one `db_pulse` line is high in any cycle.
- R10: When a command register is read and written in the same cycle, `rd_data` returns its contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | MMIO write strobe, one write per cycle |
| wr_addr | input | 16 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 16 | Byte offset to read back |
| rd_data | output | 32 | Registered read data (command registers, else 0) |
| db_pulse | output | 16 | One-cycle interrupt pulse per doorbell |

## Verification
Two functions can fall in the same cycle: a read-back of a command register and a write that triggers the same register. The bench provokes this by driving `rd_addr` and a send-bit write to that register on the same edge. It then expects the older contents on `rd_data`, the pulse on that register's doorbell line in the same sampled cycle, and the new contents (send bit cleared) one read later. Back-to-back writes that alternate between the two ranges also check that pulses coming from the command bank and from the status decoder never overlap or drop.

// File: rtl/db_map_pkg.sv
package db_map_pkg;

  localparam int unsigned DEF_NUM_CMD        = 8;
  localparam int unsigned DEF_NUM_STAT       = 8;
  localparam int unsigned DEF_CMD_BASE       = 32'h0000_A9D0;
  localparam int unsigned DEF_CMD_STRIDE     = 8;
  localparam int unsigned DEF_STAT_BASE      = 32'h0000_B180;
  localparam int unsigned DEF_STAT_STRIDE    = 4;
  localparam int unsigned DEF_STAT_IDX_FIRST = 17;
  localparam int unsigned DEF_SEND_BIT       = 13;

  // byte offset of the command word for a low-range doorbell
  function automatic int unsigned cmd_offset(int unsigned base, int unsigned stride,
                                             int unsigned line);
    return base + stride * line;
  endfunction

  // status-bank index used by a high-range doorbell (global doorbell number)
  function automatic int unsigned stat_index(int unsigned first, int unsigned num_cmd,
                                             int unsigned line);
    return line - num_cmd + first;
  endfunction

  // byte offset of a status-bank entry
  function automatic int unsigned stat_offset(int unsigned base, int unsigned stride,
                                              int unsigned idx);
    return base + stride * idx;
  endfunction

  // word with one bit dropped
  function automatic logic [31:0] drop_bit(logic [31:0] word, int unsigned pos);
    return word & ~(32'd1 << pos);
  endfunction

endpackage

// File: rtl/db_cmd_bank.sv
module db_cmd_bank
  import db_map_pkg::*;
#(
  parameter int unsigned NUM_CMD    = DEF_NUM_CMD,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned CMD_BASE   = DEF_CMD_BASE,
  parameter int unsigned CMD_STRIDE = DEF_CMD_STRIDE,
  parameter int unsigned SEND_BIT   = DEF_SEND_BIT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [31:0]        rd_data,
  output logic [NUM_CMD-1:0] fire
);

  logic [NUM_CMD-1:0] wr_hit;
  logic [NUM_CMD-1:0] rd_hit;
  logic [31:0]        cmd_q [NUM_CMD];
  logic [31:0]        rd_word;

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_slot
    localparam int unsigned SLOT_OFF = cmd_offset(CMD_BASE, CMD_STRIDE, g);
    assign wr_hit[g] = wr_en && (32'(wr_addr) == SLOT_OFF);
    assign rd_hit[g] = (32'(rd_addr) == SLOT_OFF);
    assign fire[g]   = wr_hit[g] && wr_data[SEND_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CMD; i++) cmd_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CMD; i++)
        if (wr_hit[i]) cmd_q[i] <= drop_bit(wr_data, SEND_BIT);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CMD; i++)
      if (rd_hit[i]) rd_word = cmd_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_word;
  end

endmodule

// File: rtl/db_stat_decode.sv
module db_stat_decode
  import db_map_pkg::*;
#(
  parameter int unsigned NUM_CMD       = DEF_NUM_CMD,
  parameter int unsigned NUM_STAT      = DEF_NUM_STAT,
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned STAT_BASE     = DEF_STAT_BASE,
  parameter int unsigned STAT_STRIDE   = DEF_STAT_STRIDE,
  parameter int unsigned STAT_IDX_FIRST = DEF_STAT_IDX_FIRST
) (
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  output logic [NUM_STAT-1:0] fire
);

  for (genvar g = 0; g < NUM_STAT; g++) begin : g_line
    localparam int unsigned IDX = stat_index(STAT_IDX_FIRST, NUM_CMD, NUM_CMD + g);
    localparam int unsigned OFF = stat_offset(STAT_BASE, STAT_STRIDE, IDX);
    assign fire[g] = wr_en && (32'(wr_addr) == OFF);
  end

endmodule

// File: rtl/db_pulse_stage.sv
module db_pulse_stage #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] fire_in,
  output logic [WIDTH-1:0] pulse_out
);

  always_ff @(posedge clk) begin
    if (rst) pulse_out <= '0;
    else     pulse_out <= fire_in;
  end

endmodule

// File: rtl/db_dispatch.sv
module db_dispatch
  import db_map_pkg::*;
#(
  parameter int unsigned NUM_CMD        = DEF_NUM_CMD,
  parameter int unsigned NUM_STAT       = DEF_NUM_STAT,
  parameter int unsigned ADDR_W         = 16,
  parameter int unsigned CMD_BASE       = DEF_CMD_BASE,
  parameter int unsigned CMD_STRIDE     = DEF_CMD_STRIDE,
  parameter int unsigned STAT_BASE      = DEF_STAT_BASE,
  parameter int unsigned STAT_STRIDE    = DEF_STAT_STRIDE,
  parameter int unsigned STAT_IDX_FIRST = DEF_STAT_IDX_FIRST,
  parameter int unsigned SEND_BIT       = DEF_SEND_BIT,
  localparam int unsigned NUM_LINES     = NUM_CMD + NUM_STAT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [31:0]          rd_data,
  output logic [NUM_LINES-1:0] db_pulse
);

  // named internal events, observed by the bound checker
  logic [NUM_CMD-1:0]   cmd_fire;
  logic [NUM_STAT-1:0]  stat_fire;
  logic                 cmd_any;
  logic                 stat_any;
  logic [NUM_LINES-1:0] fire_all;

  db_cmd_bank #(
    .NUM_CMD(NUM_CMD), .ADDR_W(ADDR_W), .CMD_BASE(CMD_BASE),
    .CMD_STRIDE(CMD_STRIDE), .SEND_BIT(SEND_BIT)
  ) u_cmd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fire(cmd_fire)
  );

  db_stat_decode #(
    .NUM_CMD(NUM_CMD), .NUM_STAT(NUM_STAT), .ADDR_W(ADDR_W),
    .STAT_BASE(STAT_BASE), .STAT_STRIDE(STAT_STRIDE), .STAT_IDX_FIRST(STAT_IDX_FIRST)
  ) u_stat (
    .wr_en(wr_en), .wr_addr(wr_addr), .fire(stat_fire)
  );

  assign cmd_any  = |cmd_fire;
  assign stat_any = |stat_fire;
  assign fire_all = {stat_fire, cmd_fire};

  db_pulse_stage #(.WIDTH(NUM_LINES)) u_pulse (
    .clk(clk), .rst(rst), .fire_in(fire_all), .pulse_out(db_pulse)
  );

endmodule

// File: rtl/db_dispatch_chk.sv
module db_dispatch_chk #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned SEND_BIT  = 13
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [31:0]          wr_data,
  input logic [31:0]          rd_data,
  input logic                 cmd_any,
  input logic                 stat_any,
  input logic [NUM_LINES-1:0] db_pulse
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (db_pulse == '0 && rd_data == 32'd0));

  assert_send_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[SEND_BIT]) |-> !cmd_any);

  assert_fire_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_any || stat_any) |=> ($countones(db_pulse) == 1));

  assert_no_stray_R7: assert property (@(posedge clk) disable iff (rst)
    !(cmd_any || stat_any) |=> (db_pulse == '0));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !(cmd_any || stat_any));

  assert_single_line_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(db_pulse) && !(cmd_any && stat_any));

  assert_send_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    rd_data[SEND_BIT] == 1'b0);

endmodule

bind db_dispatch db_dispatch_chk #(
  .NUM_LINES(NUM_LINES), .SEND_BIT(SEND_BIT)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .cmd_any(cmd_any), .stat_any(stat_any), .db_pulse(db_pulse)
);

// File: tb/sim_db_dispatch.sv
`timescale 1ns/1ps
module sim_db_dispatch;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] db_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  db_dispatch u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .db_pulse(db_pulse)
  );

  // {addr[15:0], data[31:0], line[4:0] (31 = none), req[3:0]}
  localparam int NV = 13;
  localparam logic [56:0] VEC [NV] = '{
    {16'hA9D0, 32'h0000_2000, 5'd0,  4'd2},
    {16'hA9E8, 32'h0000_20FF, 5'd3,  4'd2},
    {16'hAA08, 32'hFFFF_FFFF, 5'd7,  4'd2},
    {16'hA9F8, 32'h0000_1FFF, 5'd31, 4'd3},
    {16'hA9D4, 32'h0000_2000, 5'd31, 4'd7},
    {16'hB1C4, 32'h0000_0000, 5'd8,  4'd5},
    {16'hB1D0, 32'h0000_1234, 5'd11, 4'd5},
    {16'hB1E0, 32'h0000_0000, 5'd15, 4'd5},
    {16'hB1C0, 32'hFFFF_FFFF, 5'd31, 4'd6},
    {16'hB1E4, 32'h0000_0000, 5'd31, 4'd6},
    {16'hB180, 32'h0000_0000, 5'd31, 4'd6},
    {16'hA9D1, 32'h0000_2000, 5'd31, 4'd7},
    {16'hAA10, 32'h0000_2000, 5'd31, 4'd7}
  };

  function automatic string tag_of(int r);
    case (r)
      2: return "R2";
      3: return "R3";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [15:0] line_mask(int line);
    return (line > 15) ? 16'h0 : (16'h1 << line);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // write issued on one edge; returns at the negedge where the pulse is visible
  task automatic do_write(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  localparam int NS = 6;
  localparam logic [15:0] SQ_A [NS] = '{16'hA9D8, 16'hB1C8, 16'hA9F0, 16'hB1D4, 16'hA9D8, 16'hA9D8};
  localparam logic [31:0] SQ_D [NS] = '{32'h2000, 32'h0, 32'h2000, 32'h7, 32'h2000, 32'h2000};
  localparam int          SQ_L [NS] = '{1, 9, 4, 12, 1, 1};

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    check("R1", "pulse in reset", 32'(db_pulse), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "pulse after reset", 32'(db_pulse), 32'h0);
    do_read(16'hA9D0, rv);
    check("R1", "cmd0 after reset", rv, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [56:0] v;
      v = VEC[i];
      do_write(v[56:41], v[40:9]);
      check(tag_of(int'(v[3:0])), $sformatf("vec %0d pulse", i),
            32'(db_pulse), 32'(line_mask(int'(v[8:4]))));
      @(negedge clk);
      check(tag_of(int'(v[3:0])), $sformatf("vec %0d one cycle", i),
            32'(db_pulse), 32'h0);
    end

    do_read(16'hA9F8, rv);
    check("R3", "stored without send", rv, 32'h0000_1FFF);
    do_read(16'hAA08, rv);
    check("R4", "send bit reads 0", rv, 32'hFFFF_DFFF);
    do_read(16'hA9E8, rv);
    check("R4", "cmd3 readback", rv, 32'h0000_00FF);

    // read-modify-write retrigger
    do_write(16'hA9E0, 32'hDEAD_BEEF);
    check("R2", "cmd2 pulse", 32'(db_pulse), 32'(line_mask(2)));
    do_read(16'hA9E0, rv);
    check("R4", "cmd2 readback", rv, 32'hDEAD_9EEF);
    do_write(16'hA9E0, rv | 32'h2000);
    check("R4", "rmw retrigger", 32'(db_pulse), 32'(line_mask(2)));
    do_read(16'hA9E0, rv);
    check("R4", "cmd2 after rmw", rv, 32'hDEAD_9EEF);

    // unmapped writes leave registers alone
    do_write(16'hA9D8 + 16'd4, 32'hFFFF_FFFF);
    check("R7", "upper word no pulse", 32'(db_pulse), 32'h0);
    do_read(16'hA9D8, rv);
    check("R7", "cmd1 untouched", rv, 32'h0);
    do_read(16'hA9DC, rv);
    check("R7", "upper word reads 0", rv, 32'h0);

    // back-to-back across both ranges
    for (int i = 0; i < NS; i++) begin
      @(negedge clk);
      if (i > 0)
        check("R8", $sformatf("burst step %0d", i - 1), 32'(db_pulse), 32'(line_mask(SQ_L[i-1])));
      wr_en = 1'b1; wr_addr = SQ_A[i]; wr_data = SQ_D[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
    check("R8", "burst last", 32'(db_pulse), 32'(line_mask(SQ_L[NS-1])));
    @(negedge clk);
    check("R8", "burst drained", 32'(db_pulse), 32'h0);

    // read and triggering write to the same register in one cycle
    @(negedge clk);
    rd_addr = 16'hA9E0;
    wr_en = 1'b1; wr_addr = 16'hA9E0; wr_data = 32'h0000_2001;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10", "read sees old word", rd_data, 32'hDEAD_9EEF);
    check("R10", "pulse alongside read", 32'(db_pulse), 32'(line_mask(2)));
    @(negedge clk);
    check("R10", "read sees new word", rd_data, 32'h0000_0001);

    // reset during a write
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'hA9D8; wr_data = 32'h2000; rst = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R1", "write under reset", 32'(db_pulse), 32'h0);
    rst = 1'b0;
    do_read(16'hA9F8, rv);
    check("R1", "cmd5 cleared", rv, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule